// File: doc/BRIEF.md
# Paged Codec Register Access Sequencer

This block turns a single register request into the framed word sequence that a paged audio/touch codec expects on a three-wire serial link. A requester supplies a direction, a 4-bit page, a 6-bit register address, a word count and, for writes, one data word. The block then drives a word-level transfer engine. It sends a command word first and follows it with the data phases. Chip select stays asserted for the whole sequence. The engine does the bit shifting. The sequencer only decides which word goes next, whether that phase transmits or only receives, and when chip select may drop.

Reads are bursts. After the command word, the sequencer runs one receive-only phase per requested register. The codec returns consecutive registers, and each word is handed back with its register address on a one-cycle strobe. A done pulse closes a good sequence. A per-word watchdog aborts a stalled sequence, drops chip select and raises a sticky error flag.

The controller has nine states. `S_IDLE` accepts a request and goes to `S_CMD_ISSUE`. `S_CMD_ISSUE` always goes to `S_CMD_WAIT`. `S_CMD_WAIT` goes to `S_RD_ISSUE` for a read or `S_WR_ISSUE` for a write once the engine completes. `S_WR_ISSUE` always goes to `S_WR_WAIT`, which goes to `S_DONE` on completion. `S_RD_ISSUE` always goes to `S_RD_WAIT`. On completion, `S_RD_WAIT` goes back to `S_RD_ISSUE`, or to `S_DONE` after the final word. Any wait state goes to `S_FAULT` if the watchdog expires. Both `S_DONE` and `S_FAULT` return to `S_IDLE`.

Top module: `codec_reg_seq`

## Requirements
- R1: The first word of every sequence is the command word. Bit 15 is 1 for a read and 0 for a write. Bits 14:11 hold the page, bits 10:5 hold the start register address, and bits 4:0 are zero.
- R2: A write transmits exactly two words, the command word and then `req_wdata`. Both phases have `xfer_rx_only` = 0.
- R3: A read transmits the command word and then exactly N receive-only phases. Each of these has `xfer_rx_only` = 1 and `xfer_tx` = 0.
- R4: `cs_active` rises on the edge that accepts a request and is high during every `xfer_start`. It falls exactly once per sequence, on the edge where the engine completes the final word.
- R5: Read words appear on `rd_data` in request order. `rd_addr` starts at the start address and advances by one per word, wrapping modulo 64.
- R6: A read with `req_count` = 0 behaves exactly like a read with `req_count` = 1.
- R7: `rd_valid` is a one-cycle pulse per received word. `seq_done` is a one-cycle pulse one cycle after the final word completes, so for reads it comes one cycle after the last `rd_valid`.
- R8: `busy` is low out of reset and high from the cycle after acceptance until the sequence ends. `req_valid` while `busy` is high is ignored.
- R9: If `xfer_done` has not arrived by the TIMEOUT_CYC-th cycle after a phase is issued, the sequence aborts. `cs_active` drops, `seq_error` rises and no `seq_done` is produced. `seq_error` stays high until the next request is accepted.
- R10: An `xfer_done` that arrives in the same cycle as watchdog expiry counts as a normal completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_read | input | 1 | 1 = read burst, 0 = single write |
| req_page | input | 4 | Register page |
| req_addr | input | 6 | Start register address |
| req_count | input | CNT_W | Number of registers to read (0 is taken as 1) |
| req_wdata | input | 16 | Write data word |
| busy | output | 1 | A sequence is in progress |
| xfer_start | output | 1 | One-cycle phase start to the transfer engine |
| xfer_rx_only | output | 1 | Phase is receive-only |
| xfer_tx | output | 16 | Word to transmit in this phase |
| xfer_done | input | 1 | Engine finished the current phase |
| xfer_rdata | input | 16 | Word received in the finished phase |
| cs_active | output | 1 | Chip select request to the engine |
| rd_valid | output | 1 | Received word strobe |
| rd_data | output | 16 | Received word |
| rd_addr | output | 6 | Register address of the received word |
| seq_done | output | 1 | Sequence completed pulse |
| seq_error | output | 1 | Sticky watchdog abort flag |

## Verification
Engine completion and watchdog expiry can fall in the same cycle, because both are decided in the wait states. The bench provokes this by setting the modelled engine latency to exactly TIMEOUT_CYC. Such sequences must end with `seq_done`, a single chip-select fall and no error, on both the write path and the burst read path. One cycle more latency must instead give the abort. A second overlap is a new `req_valid` raised while a burst is running. It is judged by the transmitted word log and the done count, which must show only the first request.

// File: rtl/crs_pkg.sv
package crs_pkg;
    localparam int WORD_W      = 16;
    localparam int PAGE_W      = 4;
    localparam int ADDR_W      = 6;
    localparam int RD_FLAG_POS = 15;
    localparam int PAGE_POS    = 11;
    localparam int ADDR_POS    = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_ISSUE,
        S_CMD_WAIT,
        S_WR_ISSUE,
        S_WR_WAIT,
        S_RD_ISSUE,
        S_RD_WAIT,
        S_DONE,
        S_FAULT
    } seq_state_e;
endpackage

// File: rtl/crs_cmd_pack.sv
module crs_cmd_pack
    import crs_pkg::*;
(
    input  logic              is_read,
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word                     = '0;
        word[RD_FLAG_POS]        = is_read;
        word[PAGE_POS +: PAGE_W] = page;
        word[ADDR_POS +: ADDR_W] = addr;
    end
endmodule

// File: rtl/crs_burst_ctr.sv
module crs_burst_ctr
    import crs_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last
);
    localparam logic [CNT_W-1:0]  ONE_CNT  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ONE_ADDR = ADDR_W'(1);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
        end else if (load) begin
            cur_addr  <= start_addr;
            remaining <= (count == '0) ? ONE_CNT : count;
        end else if (step) begin
            cur_addr  <= cur_addr + ONE_ADDR;
            remaining <= remaining - ONE_CNT;
        end
    end

    assign last = (remaining == ONE_CNT);

    // R6
    step_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remaining > ONE_CNT));
endmodule

// File: rtl/crs_wait_timer.sv
module crs_wait_timer #(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != LAST_CNT)
            cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == LAST_CNT);

    // R9
    expire_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !run);
endmodule

// File: rtl/codec_reg_seq.sv
module codec_reg_seq
    import crs_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [3:0]        req_page,
    input  logic [5:0]        req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              xfer_start,
    output logic              xfer_rx_only,
    output logic [15:0]       xfer_tx,
    input  logic              xfer_done,
    input  logic [15:0]       xfer_rdata,
    output logic              cs_active,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [5:0]        rd_addr,
    output logic              seq_done,
    output logic              seq_error
);
    seq_state_e state, state_nx;

    logic              accept;
    logic              waiting;
    logic              expired;
    logic              burst_last;
    logic              burst_step;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] cmd_word;
    logic              lat_read;
    logic [PAGE_W-1:0] lat_page;
    logic [ADDR_W-1:0] lat_addr;
    logic [WORD_W-1:0] lat_wdata;

    assign accept  = (state == S_IDLE) && req_valid;
    assign waiting = (state == S_CMD_WAIT) || (state == S_WR_WAIT) ||
                     (state == S_RD_WAIT);
    assign burst_step = (state == S_RD_WAIT) && xfer_done && !burst_last;

    crs_cmd_pack u_cmd (
        .is_read (lat_read),
        .page    (lat_page),
        .addr    (lat_addr),
        .word    (cmd_word)
    );

    crs_burst_ctr #(.CNT_W(CNT_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .step       (burst_step),
        .start_addr (req_addr),
        .count      (req_count),
        .cur_addr   (cur_addr),
        .last       (burst_last)
    );

    crs_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state: completion outranks watchdog expiry
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (accept) state_nx = S_CMD_ISSUE;
            S_CMD_ISSUE: state_nx = S_CMD_WAIT;
            S_CMD_WAIT: begin
                if (xfer_done)    state_nx = lat_read ? S_RD_ISSUE : S_WR_ISSUE;
                else if (expired) state_nx = S_FAULT;
            end
            S_WR_ISSUE:  state_nx = S_WR_WAIT;
            S_WR_WAIT: begin
                if (xfer_done)    state_nx = S_DONE;
                else if (expired) state_nx = S_FAULT;
            end
            S_RD_ISSUE:  state_nx = S_RD_WAIT;
            S_RD_WAIT: begin
                if (xfer_done)    state_nx = burst_last ? S_DONE : S_RD_ISSUE;
                else if (expired) state_nx = S_FAULT;
            end
            S_DONE:      state_nx = S_IDLE;
            S_FAULT:     state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // phase outputs decoded from state
    assign busy         = (state != S_IDLE);
    assign xfer_start   = (state == S_CMD_ISSUE) || (state == S_WR_ISSUE) ||
                          (state == S_RD_ISSUE);
    assign xfer_rx_only = (state == S_RD_ISSUE);
    assign xfer_tx      = (state == S_CMD_ISSUE) ? cmd_word :
                          (state == S_WR_ISSUE)  ? lat_wdata : '0;

    // registered outputs and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_active <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            rd_addr   <= '0;
            seq_done  <= 1'b0;
            seq_error <= 1'b0;
            lat_read  <= 1'b0;
            lat_page  <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else begin
            rd_valid <= 1'b0;
            seq_done <= 1'b0;
            unique case (state)
                S_IDLE: if (accept) begin
                    cs_active <= 1'b1;
                    seq_error <= 1'b0;
                    lat_read  <= req_read;
                    lat_page  <= req_page;
                    lat_addr  <= req_addr;
                    lat_wdata <= req_wdata;
                end
                S_CMD_WAIT: if (!xfer_done && expired) begin
                    cs_active <= 1'b0;
                    seq_error <= 1'b1;
                end
                S_WR_WAIT: begin
                    if (xfer_done) begin
                        cs_active <= 1'b0;
                    end else if (expired) begin
                        cs_active <= 1'b0;
                        seq_error <= 1'b1;
                    end
                end
                S_RD_WAIT: begin
                    if (xfer_done) begin
                        rd_valid <= 1'b1;
                        rd_data  <= xfer_rdata;
                        rd_addr  <= cur_addr;
                        if (burst_last) cs_active <= 1'b0;
                    end else if (expired) begin
                        cs_active <= 1'b0;
                        seq_error <= 1'b1;
                    end
                end
                S_DONE:  seq_done <= 1'b1;
                default: ;
            endcase
        end
    end

    // R4
    cs_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> cs_active);

    // R3
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && xfer_rx_only) |-> (xfer_tx == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R7
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FAULT) |-> (!cs_active && seq_error));

    // R10
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && xfer_done) |=> (state != S_FAULT));

    // R8
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && state != S_DONE && state != S_FAULT) |=> busy);
endmodule

// File: tb/codec_reg_seq_tb.sv
module codec_reg_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int TMO        = 8;

    typedef struct packed {
        logic        rd;
        logic [3:0]  pg;
        logic [5:0]  ad;
        logic [3:0]  cnt;
        logic [15:0] wd;
        logic [7:0]  lat;
        logic [4:0]  nwords;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'h3, 6'h15, 4'd0,  16'hBEEF, 8'd2, 5'd0},
        '{1'b1, 4'h5, 6'h02, 4'd1,  16'h0000, 8'd1, 5'd1},
        '{1'b1, 4'hF, 6'h3E, 4'd4,  16'h0000, 8'd3, 5'd4},
        '{1'b1, 4'h1, 6'h10, 4'd0,  16'h0000, 8'd2, 5'd1},
        '{1'b0, 4'hA, 6'h3F, 4'd7,  16'h1234, 8'd8, 5'd0},
        '{1'b1, 4'h2, 6'h07, 4'd15, 16'h0000, 8'd1, 5'd15},
        '{1'b1, 4'h6, 6'h00, 4'd2,  16'h0000, 8'd8, 5'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_read = 1'b0;
    logic [3:0]       req_page = '0;
    logic [5:0]       req_addr = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic [15:0]      req_wdata = '0;
    logic             busy, xfer_start, xfer_rx_only, cs_active;
    logic [15:0]      xfer_tx, rd_data;
    logic [5:0]       rd_addr;
    logic             xfer_done = 1'b0;
    logic [15:0]      xfer_rdata = '0;
    logic             rd_valid, seq_done, seq_error;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    codec_reg_seq #(.CNT_W(CNT_W), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_page(req_page), .req_addr(req_addr), .req_count(req_count),
        .req_wdata(req_wdata), .busy(busy), .xfer_start(xfer_start),
        .xfer_rx_only(xfer_rx_only), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
        .xfer_rdata(xfer_rdata), .cs_active(cs_active), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_addr(rd_addr), .seq_done(seq_done),
        .seq_error(seq_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // engine model: answers each phase after eng_lat cycles
    int         eng_lat = 2;
    int         eng_cnt = 0;
    int         eng_idx = 0;
    logic [3:0] eng_page = '0;
    logic [5:0] eng_addr = '0;
    logic [15:0] eng_word = '0;
    always @(negedge clk) begin
        xfer_done <= 1'b0;
        if (!cs_active) eng_idx = 0;
        if (eng_cnt > 0) begin
            if (eng_cnt == 1) begin
                xfer_done  <= 1'b1;
                xfer_rdata <= eng_word;
            end
            eng_cnt = eng_cnt - 1;
        end
        if (xfer_start) begin
            if (eng_idx == 0) begin
                eng_page = xfer_tx[14:11];
                eng_addr = xfer_tx[10:5];
                eng_word = 16'h0;
            end else if (xfer_rx_only) begin
                eng_word = {2'b10, eng_page, eng_addr, 4'h5};
                eng_addr = eng_addr + 6'd1;
            end else begin
                eng_word = 16'h0;
            end
            eng_idx = eng_idx + 1;
            eng_cnt = eng_lat;
        end
    end

    // monitor logs
    logic [15:0] tx_log [256];
    logic        rx_log [256];
    logic [15:0] rd_log [256];
    logic [5:0]  ra_log [256];
    int n_tx = 0, n_rd = 0, n_done = 0, cs_falls = 0, cs_viol = 0;
    int cyc = 0, last_rdv_cyc = 0, done_cyc = 0, pulse_viol = 0;
    logic prev_cs = 1'b0, prev_rdv = 1'b0, prev_done = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (xfer_start) begin
            tx_log[n_tx[7:0]] = xfer_tx;
            rx_log[n_tx[7:0]] = xfer_rx_only;
            n_tx = n_tx + 1;
            if (!cs_active) cs_viol = cs_viol + 1;
        end
        if (rd_valid) begin
            rd_log[n_rd[7:0]] = rd_data;
            ra_log[n_rd[7:0]] = rd_addr;
            n_rd = n_rd + 1;
            last_rdv_cyc = cyc;
        end
        if (seq_done) begin
            n_done = n_done + 1;
            done_cyc = cyc;
        end
        if ((rd_valid && prev_rdv) || (seq_done && prev_done)) pulse_viol = pulse_viol + 1;
        if (prev_cs && !cs_active) cs_falls = cs_falls + 1;
        prev_cs = cs_active;
        prev_rdv = rd_valid;
        prev_done = seq_done;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cmd_of(input logic rd, input logic [3:0] pg,
                                           input logic [5:0] ad);
        return {rd, pg, ad, 5'b00000};
    endfunction

    task automatic send(input logic rd, input logic [3:0] pg, input logic [5:0] ad,
                        input logic [3:0] cnt, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_page = pg; req_addr = ad;
        req_count = cnt; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end(input int d0);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); #1;
            if (n_done != d0 || seq_error) break;
        end
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int tx0, rd0, dn0, cf0, cv0, pv0, exp_tx;
        tx0 = n_tx; rd0 = n_rd; dn0 = n_done; cf0 = cs_falls; cv0 = cs_viol;
        pv0 = pulse_viol;
        eng_lat = int'(v.lat);
        send(v.rd, v.pg, v.ad, v.cnt, v.wd);
        wait_end(dn0);
        exp_tx = v.rd ? 1 + int'(v.nwords) : 2;
        chk(!seq_error, "R10 no abort", 32'(seq_error), 0);
        chk(n_done - dn0 == 1, "R7 done count", n_done - dn0, 1);
        chk(n_tx - tx0 == exp_tx, v.rd ? "R3 phase count" : "R2 phase count",
            n_tx - tx0, exp_tx);
        chk(tx_log[tx0[7:0]] == cmd_of(v.rd, v.pg, v.ad), "R1 command word",
            32'(tx_log[tx0[7:0]]), 32'(cmd_of(v.rd, v.pg, v.ad)));
        chk(cs_falls - cf0 == 1 && cs_viol == cv0, "R4 chip select",
            cs_falls - cf0, 1);
        chk(pulse_viol == pv0, "R7 pulse width", pulse_viol - pv0, 0);
        chk(!busy, "R8 idle after", 32'(busy), 0);
        if (!v.rd) begin
            chk(tx_log[tx0[7:0]+8'd1] == v.wd && !rx_log[tx0[7:0]+8'd1],
                "R2 data word", 32'(tx_log[tx0[7:0]+8'd1]), 32'(v.wd));
        end else begin
            chk(n_rd - rd0 == int'(v.nwords), (v.cnt == 0) ? "R6 zero count" : "R5 word count",
                n_rd - rd0, v.nwords);
            for (int i = 0; i < int'(v.nwords); i++) begin
                logic [5:0]  ea;
                logic [15:0] ew;
                ea = v.ad + 6'(i);
                ew = {2'b10, v.pg, ea, 4'h5};
                chk(rx_log[8'(tx0 + 1 + i)] && tx_log[8'(tx0 + 1 + i)] == 16'h0,
                    "R3 receive phase", 32'(tx_log[8'(tx0 + 1 + i)]), 0);
                chk(rd_log[8'(rd0 + i)] == ew && ra_log[8'(rd0 + i)] == ea,
                    "R5 read order", 32'(rd_log[8'(rd0 + i)]), 32'(ew));
            end
            chk(done_cyc == last_rdv_cyc + 1, "R7 done follows last word",
                done_cyc - last_rdv_cyc, 1);
        end
        if (idx < 0) $display("unreachable");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R8 R4 reset state
        chk(!busy && !cs_active && !seq_done && !seq_error && !xfer_start && !rd_valid,
            "R8 reset state", {busy, cs_active, seq_done, seq_error, xfer_start}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R8: request raised during a running burst is ignored
        begin
            int tx0, dn0;
            tx0 = n_tx; dn0 = n_done;
            eng_lat = 4;
            send(1'b1, 4'h9, 6'h20, 4'd3, 16'h0);
            repeat (3) @(negedge clk);
            #1;
            chk(busy, "R8 busy mid burst", 32'(busy), 1);
            req_valid = 1'b1; req_read = 1'b0; req_page = 4'h1; req_addr = 6'h01;
            req_count = 4'd0; req_wdata = 16'hDEAD;
            @(negedge clk);
            req_valid = 1'b0;
            wait_end(dn0);
            chk(n_tx - tx0 == 4 && n_done - dn0 == 1, "R8 busy request ignored",
                n_tx - tx0, 4);
            chk(tx_log[tx0[7:0]] == cmd_of(1'b1, 4'h9, 6'h20), "R8 first command kept",
                32'(tx_log[tx0[7:0]]), 32'(cmd_of(1'b1, 4'h9, 6'h20)));
        end

        // R9: engine one cycle too slow -> abort
        begin
            int dn0;
            dn0 = n_done;
            eng_lat = TMO + 1;
            send(1'b0, 4'h4, 6'h0A, 4'd0, 16'h5555);
            wait_end(dn0);
            chk(seq_error && !cs_active, "R9 abort flags", {seq_error, cs_active}, 2'b10);
            chk(n_done == dn0, "R9 no done on abort", n_done - dn0, 0);
            repeat (20) @(negedge clk);
            #1;
            chk(seq_error && !busy, "R9 error sticky", {seq_error, busy}, 2'b10);
            eng_lat = 2;
            send(1'b1, 4'h7, 6'h05, 4'd1, 16'h0);
            #1;
            chk(!seq_error, "R9 error cleared on accept", 32'(seq_error), 0);
            wait_end(dn0);
            chk(n_done - dn0 == 1 && !seq_error, "R9 recovery", n_done - dn0, 1);
        end

        // R9: stall during a read burst data phase
        begin
            int dn0, rd0;
            dn0 = n_done; rd0 = n_rd;
            eng_lat = 2;
            send(1'b1, 4'h3, 6'h30, 4'd5, 16'h0);
            repeat (8) @(negedge clk);
            eng_lat = 200;
            wait_end(dn0);
            chk(seq_error && !cs_active && n_done == dn0, "R9 mid burst abort",
                {seq_error, cs_active}, 2'b10);
            chk(n_rd - rd0 < 5, "R9 burst cut short", n_rd - rd0, 1);
            repeat (220) @(negedge clk);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule